// File: doc/BRIEF.md
# DMA Channel Register Bank

This block is the programmable register bank that sits in front of four DMA channel engines. A processor-side bus issues 16-bit or 32-bit accesses with an 8-bit low address. The block decodes that address into a channel and a field. It holds each channel's source address, destination address, transfer count and control halfword, and presents all of them as flat output vectors to the engines.

Each channel has its own address widths and count width. The last channel has a wider destination address and a wider count than the others, and channel 0 has a narrower source address than the others. Halfword writes update one half of a 32-bit address register. Only the control halfword can be read back. When software sets a channel's enable bit, a one-cycle start pulse goes to that channel's engine.

The bus side uses plain strobes and has no back-pressure. An access is taken in the cycle that `bus_en` is high. Read data appears one cycle later, together with `rd_valid`.

Top module: `dma_regfile`

## Requirements
- R1: After reset every address, count and control output is zero, and `start_o`, `rd_valid` and `err_o` are low.
- R2: Channel n occupies 12 bytes at 0xB0 + 12n. The source address is at +0, the destination address at +4, the count halfword at +8 and the control halfword at +10. `bus_size` encodes 0 = byte, 1 = halfword, 2 = word, 3 = reserved.
- R3: A written source address is masked to 27 bits on channel 0 and to 28 bits on every other channel.
- R4: A written destination address is masked to 28 bits on the last channel and to 27 bits on every other channel.
- R5: The count register keeps 16 bits on the last channel and 14 bits on the others. Higher written bits are dropped.
- R6: A halfword write takes its data from `bus_wdata[15:0]`. It replaces only the addressed half of a source or destination register, and the mask is applied to the merged value.
- R7: A word write at +8 loads the count from bits 15:0 and the control halfword from bits 31:16 in the same cycle.
- R8: A halfword read at +10 returns {16'h0, control}. A word read at +8 returns {control, 16'h0}. Every other defined read returns 0. `rd_valid` and `rd_data` appear in the cycle after a halfword or word read.
- R9: Byte and reserved-size accesses change no register, raise no `rd_valid` and do not set `err_o`.
- R10: A halfword or word access to an undefined location reads as 0, changes no register and sets the sticky `err_o`, which only reset clears. Undefined locations are outside the window, an odd address, or a word access not at +0, +4 or +8.
- R11: A write that takes control bit 15 from 0 to 1 raises that channel's `start_o` bit for exactly one cycle, starting in the cycle after the write. A write while bit 15 is already set raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size code |
| bus_addr | input | 8 | Low address byte |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| src_o | output | 32*NUM_CH | Source addresses, channel n at [32n +: 32] |
| dst_o | output | 32*NUM_CH | Destination addresses |
| cnt_o | output | 16*NUM_CH | Counts, zero-extended |
| ctl_o | output | 16*NUM_CH | Control halfwords |
| start_o | output | NUM_CH | Start pulses |
| err_o | output | 1 | Sticky undefined-access flag |

## Verification
The bench builds the block with the default four channels at base 0xB0. With that setting, channel 0, the middle channels and the last channel each follow a different set of mask and count widths, so every width variant is checked against a value that overflows it. The four-channel window also puts its first byte past the end at 0xE0, which exercises the out-of-window error path.

// File: rtl/dma_reg_pkg.sv
package dma_reg_pkg;
  localparam int ADDR_W_NARROW = 27;
  localparam int ADDR_W_WIDE   = 28;
  localparam int CNT_W_NARROW  = 14;
  localparam int CNT_W_WIDE    = 16;
  localparam int CH_STRIDE     = 12;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic src_lo;
    logic src_hi;
    logic dst_lo;
    logic dst_hi;
    logic cnt;
    logic ctl;
  } fsel_t;

  function automatic int src_w(input int ch);
    return (ch == 0) ? ADDR_W_NARROW : ADDR_W_WIDE;
  endfunction

  function automatic int dst_w(input int ch, input int nch);
    return (ch == nch - 1) ? ADDR_W_WIDE : ADDR_W_NARROW;
  endfunction

  function automatic int cnt_w(input int ch, input int nch);
    return (ch == nch - 1) ? CNT_W_WIDE : CNT_W_NARROW;
  endfunction
endpackage

// File: rtl/dma_addr_decode.sv
module dma_addr_decode
  import dma_reg_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int BASE   = 8'hB0,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            acc_en,
  input  logic [1:0]      acc_size,
  input  logic [7:0]      acc_addr,
  output logic [CH_W-1:0] dec_ch,
  output fsel_t           dec_sel,
  output logic            dec_bad
);
  logic       in_win;
  logic [3:0] sub;
  logic       sized;

  always_comb begin
    in_win = 1'b0;
    sub    = '0;
    dec_ch = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      int rel;
      rel = int'(acc_addr) - BASE - c * CH_STRIDE;
      if (rel >= 0 && rel < CH_STRIDE) begin
        in_win = 1'b1;
        sub    = 4'(rel);
        dec_ch = CH_W'(c);
      end
    end
  end

  assign sized = (acc_size == SZ_HALF) || (acc_size == SZ_WORD);

  always_comb begin
    dec_sel = '0;
    if (in_win && acc_size == SZ_HALF) begin
      case (sub)
        4'd0:    dec_sel.src_lo = 1'b1;
        4'd2:    dec_sel.src_hi = 1'b1;
        4'd4:    dec_sel.dst_lo = 1'b1;
        4'd6:    dec_sel.dst_hi = 1'b1;
        4'd8:    dec_sel.cnt    = 1'b1;
        4'd10:   dec_sel.ctl    = 1'b1;
        default: dec_sel = '0;
      endcase
    end else if (in_win && acc_size == SZ_WORD) begin
      case (sub)
        4'd0:    begin dec_sel.src_lo = 1'b1; dec_sel.src_hi = 1'b1; end
        4'd4:    begin dec_sel.dst_lo = 1'b1; dec_sel.dst_hi = 1'b1; end
        4'd8:    begin dec_sel.cnt    = 1'b1; dec_sel.ctl    = 1'b1; end
        default: dec_sel = '0;
      endcase
    end
  end

  assign dec_bad = acc_en && sized && (dec_sel == '0);
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_reg_pkg::*;
#(
  parameter int CH     = 0,
  parameter int NUM_CH = 4,
  localparam int SW    = src_w(CH),
  localparam int DW    = dst_w(CH, NUM_CH),
  localparam int CW    = cnt_w(CH, NUM_CH),
  localparam logic [31:0] SRC_MASK = 32'((64'd1 << SW) - 1),
  localparam logic [31:0] DST_MASK = 32'((64'd1 << DW) - 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  fsel_t       wr,
  input  logic [15:0] lo_data,
  input  logic [15:0] hi_data,
  output logic [31:0] src,
  output logic [31:0] dst,
  output logic [15:0] cnt,
  output logic [15:0] ctl,
  output logic        start
);
  logic [31:0]   src_q, dst_q;
  logic [CW-1:0] cnt_q;
  logic [15:0]   ctl_q;
  logic          start_q;
  logic [31:0]   src_nx, dst_nx;

  always_comb begin
    src_nx = {wr.src_hi ? hi_data : src_q[31:16],
              wr.src_lo ? lo_data : src_q[15:0]} & SRC_MASK;
    dst_nx = {wr.dst_hi ? hi_data : dst_q[31:16],
              wr.dst_lo ? lo_data : dst_q[15:0]} & DST_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      ctl_q   <= '0;
      start_q <= 1'b0;
    end else begin
      if (wr.src_lo || wr.src_hi) src_q <= src_nx;
      if (wr.dst_lo || wr.dst_hi) dst_q <= dst_nx;
      if (wr.cnt) cnt_q <= lo_data[CW-1:0];
      if (wr.ctl) ctl_q <= hi_data;
      start_q <= wr.ctl && !ctl_q[15] && hi_data[15];
    end
  end

  assign src   = src_q;
  assign dst   = dst_q;
  assign cnt   = 16'(cnt_q);
  assign ctl   = ctl_q;
  assign start = start_q;

  // R11
  start_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> (ctl_q[15] && !$past(ctl_q[15])));

  // R9
  src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr.src_lo || wr.src_hi) |-> $stable(src_q));

  // R9
  dst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr.dst_lo || wr.dst_hi) |-> $stable(dst_q));

  // R5
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr.cnt) |-> $stable(cnt_q));
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_reg_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int BASE   = 8'hB0,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_en,
  input  logic                 bus_we,
  input  logic [1:0]           bus_size,
  input  logic [7:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic                 rd_valid,
  output logic [31:0]          rd_data,
  output logic [32*NUM_CH-1:0] src_o,
  output logic [32*NUM_CH-1:0] dst_o,
  output logic [16*NUM_CH-1:0] cnt_o,
  output logic [16*NUM_CH-1:0] ctl_o,
  output logic [NUM_CH-1:0]    start_o,
  output logic                 err_o
);
  logic [CH_W-1:0] dec_ch;
  fsel_t           dec_sel;
  logic            dec_bad;
  logic [15:0]     lo_data, hi_data;
  logic [15:0]     ctl_arr [NUM_CH];
  logic            rd_take;
  logic [15:0]     ctl_sel;

  dma_addr_decode #(.NUM_CH(NUM_CH), .BASE(BASE)) u_dec (
    .acc_en   (bus_en),
    .acc_size (bus_size),
    .acc_addr (bus_addr),
    .dec_ch   (dec_ch),
    .dec_sel  (dec_sel),
    .dec_bad  (dec_bad)
  );

  assign lo_data = bus_wdata[15:0];
  assign hi_data = (bus_size == SZ_WORD) ? bus_wdata[31:16] : bus_wdata[15:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    fsel_t wr_c;
    assign wr_c = (bus_en && bus_we && dec_ch == CH_W'(c)) ? dec_sel : '0;

    dma_chan_regs #(.CH(c), .NUM_CH(NUM_CH)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (wr_c),
      .lo_data (lo_data),
      .hi_data (hi_data),
      .src     (src_o[32*c +: 32]),
      .dst     (dst_o[32*c +: 32]),
      .cnt     (cnt_o[16*c +: 16]),
      .ctl     (ctl_arr[c]),
      .start   (start_o[c])
    );
    assign ctl_o[16*c +: 16] = ctl_arr[c];
  end

  assign rd_take = bus_en && !bus_we && (bus_size == SZ_HALF || bus_size == SZ_WORD);
  assign ctl_sel = ctl_arr[dec_ch];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      err_o    <= 1'b0;
    end else begin
      rd_valid <= rd_take;
      if (rd_take) begin
        if (dec_sel.ctl && bus_size == SZ_HALF)      rd_data <= {16'h0, ctl_sel};
        else if (dec_sel.ctl && bus_size == SZ_WORD) rd_data <= {ctl_sel, 16'h0};
        else                                         rd_data <= '0;
      end
      if (dec_bad) err_o <= 1'b1;
    end
  end

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_o) |-> err_o);

  // R11
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_o));

  // R8
  rd_valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(bus_en && !bus_we));

  // R9
  byte_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_size == SZ_BYTE && !err_o) |=> !err_o);
endmodule

// File: tb/dma_regfile_bench.sv
module dma_regfile_bench;
  localparam int NUM_CH = 4;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 bus_en = 1'b0;
  logic                 bus_we = 1'b0;
  logic [1:0]           bus_size = 2'd0;
  logic [7:0]           bus_addr = 8'h0;
  logic [31:0]          bus_wdata = 32'h0;
  logic                 rd_valid;
  logic [31:0]          rd_data;
  logic [32*NUM_CH-1:0] src_o, dst_o;
  logic [16*NUM_CH-1:0] cnt_o, ctl_o;
  logic [NUM_CH-1:0]    start_o;
  logic                 err_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  dma_regfile #(.NUM_CH(NUM_CH)) u_dma_regfile (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .src_o(src_o), .dst_o(dst_o),
    .cnt_o(cnt_o), .ctl_o(ctl_o), .start_o(start_o), .err_o(err_o)
  );

  // sel: 0 rd_data, 1 src, 2 dst, 3 cnt, 4 ctl, 5 rd_valid, 6 err
  typedef struct packed {
    logic        we;
    logic [1:0]  sz;
    logic [7:0]  addr;
    logic [31:0] wd;
    logic [2:0]  sel;
    logic [1:0]  ch;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd2, 8'hB0, 32'hFFFF_FFFF, 3'd1, 2'd0, 32'h07FF_FFFF, 4'd3}, // R3
    '{1'b1, 2'd2, 8'hBC, 32'hFFFF_FFFF, 3'd1, 2'd1, 32'h0FFF_FFFF, 4'd3}, // R3
    '{1'b1, 2'd2, 8'hB4, 32'hFFFF_FFFF, 3'd2, 2'd0, 32'h07FF_FFFF, 4'd4}, // R4
    '{1'b1, 2'd2, 8'hD8, 32'hFFFF_FFFF, 3'd2, 2'd3, 32'h0FFF_FFFF, 4'd4}, // R4
    '{1'b1, 2'd2, 8'hCC, 32'hFFFF_FFFF, 3'd2, 2'd2, 32'h07FF_FFFF, 4'd4}, // R4, R2
    '{1'b1, 2'd1, 8'hB8, 32'h0000_FFFF, 3'd3, 2'd0, 32'h0000_3FFF, 4'd5}, // R5
    '{1'b1, 2'd1, 8'hDC, 32'h0000_FFFF, 3'd3, 2'd3, 32'h0000_FFFF, 4'd5}, // R5
    '{1'b1, 2'd1, 8'hC2, 32'h0000_1234, 3'd2, 2'd1, 32'h0234_0000, 4'd6}, // R6
    '{1'b1, 2'd1, 8'hC0, 32'h0000_ABCD, 3'd2, 2'd1, 32'h0234_ABCD, 4'd6}, // R6
    '{1'b1, 2'd2, 8'hD0, 32'h1234_5678, 3'd3, 2'd2, 32'h0000_1678, 4'd7}, // R7
    '{1'b0, 2'd2, 8'hD0, 32'h0,         3'd0, 2'd0, 32'h1234_0000, 4'd7}, // R7, R8
    '{1'b0, 2'd1, 8'hD2, 32'h0,         3'd0, 2'd0, 32'h0000_1234, 4'd8}, // R8
    '{1'b0, 2'd2, 8'hB0, 32'h0,         3'd0, 2'd0, 32'h0000_0000, 4'd8}, // R8
    '{1'b1, 2'd0, 8'hBA, 32'h0000_8000, 3'd4, 2'd0, 32'h0000_0000, 4'd9}, // R9
    '{1'b0, 2'd0, 8'hBA, 32'h0,         3'd5, 2'd0, 32'h0000_0000, 4'd9}, // R9
    '{1'b1, 2'd2, 8'hE0, 32'hFFFF_FFFF, 3'd6, 2'd0, 32'h0000_0001, 4'd10}, // R10
    '{1'b0, 2'd1, 8'hB1, 32'h0,         3'd0, 2'd0, 32'h0000_0000, 4'd10}  // R10
  };

  task automatic check(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [1:0] sz,
                        input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = we; bus_size = sz; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  function automatic logic [31:0] pick(input logic [2:0] sel, input int ch);
    case (sel)
      3'd0: return rd_data;
      3'd1: return src_o[32*ch +: 32];
      3'd2: return dst_o[32*ch +: 32];
      3'd3: return 32'(cnt_o[16*ch +: 16]);
      3'd4: return 32'(ctl_o[16*ch +: 16]);
      3'd5: return 32'(rd_valid);
      default: return 32'(err_o);
    endcase
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(1, "src_o", src_o[31:0] | src_o[127:96], 32'h0);
    check(1, "ctl/cnt", {ctl_o[15:0], cnt_o[63:48]}, 32'h0);
    check(1, "flags", {28'h0, rd_valid, err_o, start_o[1:0]} | 32'(start_o), 32'h0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].we, VEC[i].sz, VEC[i].addr, VEC[i].wd);
      check(int'(VEC[i].req), $sformatf("vector %0d", i),
            pick(VEC[i].sel, int'(VEC[i].ch)), VEC[i].exp);
    end

    // R11 enable rising edge on channel 0 via halfword write
    access(1'b1, 2'd1, 8'hBA, 32'h0000_8000);
    check(11, "start pulse ch0", 32'(start_o), 32'h1);
    @(negedge clk);
    check(11, "start pulse width", 32'(start_o), 32'h0);
    access(1'b1, 2'd1, 8'hBA, 32'h0000_8001);
    check(11, "no pulse when already enabled", 32'(start_o), 32'h0);
    // R7 R11 word write on last channel sets count and enable together
    access(1'b1, 2'd2, 8'hDC, 32'h8000_0005);
    check(11, "start pulse ch3", 32'(start_o), 32'h8);
    check(7, "cnt ch3", 32'(cnt_o[63:48]), 32'h5);
    // R10 write outside window leaves registers untouched
    access(1'b1, 2'd1, 8'hAE, 32'h0000_0000);
    check(10, "ctl ch0 after stray write", 32'(ctl_o[15:0]), 32'h8001);
    // R1 reset clears sticky error
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check(1, "err after reset", 32'(err_o), 32'h0);
    check(1, "ctl ch3 after reset", 32'(ctl_o[63:48]), 32'h0);
    finish_run();
  end
endmodule